// File: doc/BRIEF.md
# Converter Serial Host with Shared Data-Ready Line

This block is the host side of a serial link to a sampling converter whose data-output pin serves two purposes. During a transfer it carries the bits read back from the converter. Between transfers, while chip select is low, a low level on that pin tells the host that a conversion has finished and a result is waiting. The controller generates the serial clock, sends a one-byte command that names a register and the transfer direction, and then either shifts out write data or collects a result of 8, 16, 24 or 32 bits.

Host logic uses a simple request/response handshake. A request carries a direction, a register address, a length code and write data. The controller answers with a one-cycle response strobe. When auto-read is enabled, the controller watches the shared line itself. It starts a read of a fixed data register as soon as a ready indication is qualified, then presents the result with its own strobe. A ready indication that disappears without being read is recorded as a sticky overrun. A build-time option holds chip select low permanently for three-wire wiring. In that case ready is taken from the data line alone.

Top module: `cnv_serial_host`

## Requirements
- R1: After reset, chip select is high (four-wire build), the serial clock is high, the serial output is 0, and `req_busy`, `rsp_valid`, `auto_valid`, `cnv_ready` and `ovr_flag` are all 0.
- R2: The serial clock idles high and toggles only while chip select is low, with a period of `DIV` system clocks. Output bits change on its falling edge, most significant bit first. Input bits are sampled on its rising edge.
- R3: Each transfer begins with a command byte. Bit 7 is 0. Bit 6 is 1 for a read and 0 for a write. Bits 5:0 hold the register address.
- R4: A read of length code 0, 1, 2 or 3 collects 8, 16, 24 or 32 bits after the command byte. The result appears right-aligned and zero-filled on `rsp_rdata`, together with a `rsp_valid` pulse that lasts one cycle.
- R5: A write sends the low 8, 16, 24 or 32 bits of `req_wdata`, as chosen by the length code, after the command byte. It completes with a `rsp_valid` pulse and `rsp_rdata` equal to 0.
- R6: A request that arrives while a transfer runs sees `req_busy` high. It is stored and then executed when the running transfer ends, so each request receives its own response in the order issued.
- R7: In the four-wire build, chip select is low only during a transfer or while `auto_rd_en` is 1. While chip select is high, `miso` is ignored: it produces neither `cnv_ready` nor `ovr_flag`.
- R8: While idle with chip select low, `cnv_ready` rises only after `miso` has been seen high and then low at two consecutive system clock edges. A low level that lasts for a single clock is ignored.
- R9: With `auto_rd_en` set, a qualified ready starts a read of register `AUTO_ADDR` with length code `AUTO_LEN`. The result is returned on `auto_data` with a one-cycle `auto_valid` and without `rsp_valid`.
- R10: If a pending ready line returns high for two consecutive clocks before any transfer starts, `ovr_flag` is set. It stays set until reset.
- R11: In the three-wire build (`THREE_WIRE`=1), chip select is held low at all times, and ready detection and overrun work from `miso` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rd_en | input | 1 | Enables ready monitoring with automatic reads |
| req_valid | input | 1 | One-cycle host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Target register address |
| req_len | input | 2 | Data length code: 0..3 gives 8..32 bits |
| req_wdata | input | 32 | Write data, right-aligned |
| req_busy | output | 1 | A transfer runs or a request is held |
| rsp_valid | output | 1 | One-cycle completion strobe for host requests |
| rsp_rdata | output | 32 | Read result, right-aligned; 0 after a write |
| auto_valid | output | 1 | One-cycle strobe for an automatic read result |
| auto_data | output | 32 | Automatic read result, right-aligned |
| cnv_ready | output | 1 | Qualified ready seen and not yet consumed |
| ovr_flag | output | 1 | Sticky overrun: a ready pulse was missed |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data and ready flag from the converter |

## Verification
The checker assumes a host that raises `req_valid` only when `req_busy` is low, or at most once while a transfer runs. It also assumes that `auto_rd_en` changes only while the link is idle and that the converter changes `miso` only after a falling serial clock edge. The bench issues every request through a task that leaves at least one idle cycle between strobes. It submits a second request only during an active transfer whose holding slot is empty. Its converter model updates `miso` only on the serial clock falling edge. Ready and overrun stimulus is applied only while no transfer runs.

// File: rtl/cnv_serial_pkg.sv
package cnv_serial_pkg;

   localparam int CMD_W   = 8;
   localparam int ADDR_W  = 6;
   localparam int DATA_W  = 32;
   localparam int FRAME_W = CMD_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [1:0]        len;
      logic [DATA_W-1:0] wdata;
   } xfer_req_t;

   // length code 0..3 -> 8..32 data bits
   function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] len);
      return {({1'b0, len} + 3'd1), 3'b000};
   endfunction

   // bit 7 zero, bit 6 set for a read, bits 5:0 address
   function automatic logic [CMD_W-1:0] cmd_byte(input logic wr, input logic [ADDR_W-1:0] addr);
      return {1'b0, ~wr, addr};
   endfunction

endpackage

// File: rtl/cnv_bit_engine.sv
module cnv_bit_engine
   import cnv_serial_pkg::*;
#(
   parameter int unsigned DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  xfer_req_t         req,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned HALF = DIV / 2;
   localparam int          PW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic               active;
   logic               sclk_r;
   logic               done_r;
   logic [PW-1:0]      phase;
   logic [CNT_W-1:0]   bitn;
   logic [CNT_W-1:0]   total;
   logic [FRAME_W-1:0] tx;
   logic [DATA_W-1:0]  rx;
   logic               phase_end;
   logic [CNT_W-1:0]   nbits;

   assign nbits     = data_bits(req.len);
   assign phase_end = (phase == PW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk_r <= 1'b1;
         done_r <= 1'b0;
         phase  <= '0;
         bitn   <= '0;
         total  <= '0;
         tx     <= '0;
         rx     <= '0;
      end else begin
         done_r <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               sclk_r <= 1'b1;
               phase  <= '0;
               bitn   <= '0;
               total  <= CNT_W'(CMD_W) + nbits;
               tx     <= {cmd_byte(req.wr, req.addr),
                          req.wdata << (CNT_W'(DATA_W) - nbits)};
               rx     <= '0;
            end
         end else if (phase_end) begin
            phase <= '0;
            if (sclk_r) begin
               if (bitn == total) begin
                  active <= 1'b0;
                  done_r <= 1'b1;
               end else begin
                  sclk_r <= 1'b0;
                  if (bitn != '0) tx <= {tx[FRAME_W-2:0], 1'b0};
               end
            end else begin
               sclk_r <= 1'b1;
               bitn   <= bitn + CNT_W'(1);
               if (bitn >= CNT_W'(CMD_W)) rx <= {rx[DATA_W-2:0], miso};
            end
         end else begin
            phase <= phase + PW'(1);
         end
      end
   end

   assign sclk  = sclk_r;
   assign mosi  = active & tx[FRAME_W-1];
   assign busy  = active;
   assign done  = done_r;
   assign rdata = rx;

endmodule

// File: rtl/cnv_ready_watch.sv
module cnv_ready_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic miso,
   input  logic mon,
   output logic evt,
   output logic pend,
   output logic ovr
);

   logic miso_q;
   logic armed;
   logic lo2;
   logic hi2;

   assign lo2 = ~miso & ~miso_q;
   assign hi2 = miso & miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miso_q <= 1'b1;
         armed  <= 1'b0;
         pend   <= 1'b0;
         ovr    <= 1'b0;
         evt    <= 1'b0;
      end else begin
         miso_q <= miso;
         evt    <= 1'b0;
         if (!mon) begin
            armed <= 1'b0;
            pend  <= 1'b0;
         end else if (hi2) begin
            armed <= 1'b1;
            if (pend) begin
               ovr  <= 1'b1;
               pend <= 1'b0;
            end
         end else if (lo2 && armed) begin
            armed <= 1'b0;
            pend  <= 1'b1;
            evt   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cnv_serial_host.sv
module cnv_serial_host
   import cnv_serial_pkg::*;
#(
   parameter int unsigned       DIV        = 4,
   parameter bit                THREE_WIRE = 1'b0,
   parameter logic [ADDR_W-1:0] AUTO_ADDR  = 6'h04,
   parameter logic [1:0]        AUTO_LEN   = 2'd2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_rd_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              auto_valid,
   output logic [DATA_W-1:0] auto_data,
   output logic              cnv_ready,
   output logic              ovr_flag,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("cnv_serial_host: DIV must be even and at least 2");
      end
   endgenerate

   logic              eng_busy;
   logic              eng_done;
   logic [DATA_W-1:0] eng_rdata;
   logic              start;
   logic              start_auto;
   xfer_req_t         start_req;
   logic              hold_v;
   xfer_req_t         hold_q;
   logic              cur_write;
   logic              cur_auto;
   logic              rdy_evt;
   logic              mon;

   // priority when idle: held request, new request, ready event
   always_comb begin
      start      = 1'b0;
      start_auto = 1'b0;
      start_req  = hold_q;
      if (!eng_busy) begin
         if (hold_v) begin
            start = 1'b1;
         end else if (req_valid) begin
            start           = 1'b1;
            start_req.wr    = req_write;
            start_req.addr  = req_addr;
            start_req.len   = req_len;
            start_req.wdata = req_wdata;
         end else if (rdy_evt && auto_rd_en) begin
            start           = 1'b1;
            start_auto      = 1'b1;
            start_req.wr    = 1'b0;
            start_req.addr  = AUTO_ADDR;
            start_req.len   = AUTO_LEN;
            start_req.wdata = '0;
         end
      end
   end

   generate
      if (THREE_WIRE) begin : g_cs_tied
         assign cs_n = 1'b0;
      end else begin : g_cs_driven
         assign cs_n = ~(eng_busy | auto_rd_en);
      end
   endgenerate

   assign mon      = ~cs_n & ~eng_busy & ~start;
   assign req_busy = eng_busy | hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v     <= 1'b0;
         hold_q     <= '0;
         cur_write  <= 1'b0;
         cur_auto   <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         auto_valid <= 1'b0;
         auto_data  <= '0;
      end else begin
         if (!eng_busy && hold_v) begin
            hold_v <= 1'b0;
         end else if (eng_busy && req_valid && !hold_v) begin
            hold_v       <= 1'b1;
            hold_q.wr    <= req_write;
            hold_q.addr  <= req_addr;
            hold_q.len   <= req_len;
            hold_q.wdata <= req_wdata;
         end
         if (start) begin
            cur_write <= start_req.wr;
            cur_auto  <= start_auto;
         end
         rsp_valid  <= 1'b0;
         auto_valid <= 1'b0;
         if (eng_done) begin
            if (cur_auto) begin
               auto_valid <= 1'b1;
               auto_data  <= eng_rdata;
            end else begin
               rsp_valid <= 1'b1;
               rsp_rdata <= cur_write ? '0 : eng_rdata;
            end
         end
      end
   end

   cnv_bit_engine #(.DIV(DIV)) u_engine (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .req   (start_req),
      .miso  (miso),
      .sclk  (sclk),
      .mosi  (mosi),
      .busy  (eng_busy),
      .done  (eng_done),
      .rdata (eng_rdata)
   );

   cnv_ready_watch u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .miso  (miso),
      .mon   (mon),
      .evt   (rdy_evt),
      .pend  (cnv_ready),
      .ovr   (ovr_flag)
   );

endmodule

// File: rtl/cnv_serial_host_chk.sv
module cnv_serial_host_chk #(
   parameter bit THREE_WIRE = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic req_busy,
   input logic rsp_valid,
   input logic auto_valid,
   input logic ovr_flag
);

   assert_sclk_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !cs_n);

   assert_low_clock_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk |-> req_busy);

   assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_auto_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      auto_valid |=> !auto_valid);

   assert_auto_not_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      auto_valid |-> !rsp_valid);

   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);

   generate
      if (THREE_WIRE) begin : g_tied
         assert_cs_tied_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n);
      end
   endgenerate

endmodule

bind cnv_serial_host cnv_serial_host_chk #(.THREE_WIRE(THREE_WIRE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .sclk       (sclk),
   .req_busy   (req_busy),
   .rsp_valid  (rsp_valid),
   .auto_valid (auto_valid),
   .ovr_flag   (ovr_flag)
);

// File: tb/cnv_serial_host_test.sv
`timescale 1ns/1ps
module cnv_serial_host_test;

   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        auto_rd_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [1:0]  req_len = '0;
   logic [31:0] req_wdata = '0;
   logic        req_busy, rsp_valid, auto_valid, cnv_ready, ovr_flag;
   logic [31:0] rsp_rdata, auto_data;
   logic        cs_n, sclk, mosi, miso;

   logic        busy3, rv3, av3, rdy3, ovr3, cs3_n, sclk3, mosi3;
   logic [31:0] rd3, ad3;
   logic        level3 = 1'b1;
   logic        cs3_bad = 1'b0;

   // converter model
   logic        level = 1'b1;
   logic        mclr = 1'b0;
   logic        mbit = 1'b1;
   logic [31:0] mdata = '0;
   int          mbits = 8;
   int          mcnt = 0;
   logic [63:0] cap = '0;

   always @(posedge sclk or posedge mclr) begin
      if (mclr) mcnt = 0;
      else begin
         mcnt = mcnt + 1;
         cap  = {cap[62:0], mosi};
      end
   end
   always @(negedge sclk) begin
      if (mcnt >= 8 && mcnt < 8 + mbits) mbit = mdata[mbits - 1 - (mcnt - 8)];
   end
   assign miso = (!cs_n && mcnt >= 8) ? mbit : level;

   cnv_serial_host #(.DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .auto_rd_en(auto_rd_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_len(req_len), .req_wdata(req_wdata), .req_busy(req_busy),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .auto_valid(auto_valid),
      .auto_data(auto_data), .cnv_ready(cnv_ready), .ovr_flag(ovr_flag),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   cnv_serial_host #(.DIV(DIV), .THREE_WIRE(1'b1)) uut3 (
      .clk(clk), .rst_n(rst_n), .auto_rd_en(1'b0),
      .req_valid(1'b0), .req_write(1'b0), .req_addr(6'h00),
      .req_len(2'd0), .req_wdata(32'h0), .req_busy(busy3),
      .rsp_valid(rv3), .rsp_rdata(rd3), .auto_valid(av3),
      .auto_data(ad3), .cnv_ready(rdy3), .ovr_flag(ovr3),
      .cs_n(cs3_n), .sclk(sclk3), .mosi(mosi3), .miso(level3)
   );

   always @(negedge clk) if (rst_n && cs3_n !== 1'b0) cs3_bad = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse_mclr();
      @(negedge clk); mclr = 1'b1;
      @(negedge clk); mclr = 1'b0;
   endtask

   task automatic host_req(input logic wr, input logic [5:0] a, input logic [1:0] l,
                           input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(input string tag, output logic [31:0] d);
      bit got;
      got = 0; d = '0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (rsp_valid) begin d = rsp_rdata; got = 1; break; end
      end
      chk({tag, " response arrives"}, 64'(got), 64'd1);
   endtask

   // {write, addr[5:0], len[1:0], data[31:0]}
   localparam logic [40:0] VEC [6] = '{
      {1'b0, 6'h04, 2'd3, 32'hA5C3_1E7F},
      {1'b0, 6'h07, 2'd0, 32'h1234_5681},
      {1'b1, 6'h01, 2'd1, 32'h0000_8C1D},
      {1'b0, 6'h3F, 2'd2, 32'h00F0_0F55},
      {1'b1, 6'h20, 2'd3, 32'h8000_0001},
      {1'b0, 6'h02, 2'd1, 32'hFFFF_FFFF}
   };

   initial begin
      for (int k = 0; k < 150000; k++) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] mask;
      int          nb, per, rsp_seen;
      bit          got;

      // R1 reset state
      wait_clk(3);
      chk("R1 cs_n", 64'(cs_n), 64'd1);
      chk("R1 sclk", 64'(sclk), 64'd1);
      chk("R1 mosi", 64'(mosi), 64'd0);
      chk("R1 flags", {59'd0, req_busy, rsp_valid, auto_valid, cnv_ready, ovr_flag}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      wait_clk(2);

      // R7 line ignored while chip select high
      level = 1'b0; wait_clk(10);
      chk("R7 ready ignored while deselected", 64'(cnv_ready), 64'd0);
      level = 1'b1; wait_clk(6);
      chk("R7 no overrun while deselected", 64'(ovr_flag), 64'd0);

      // R2..R5 vector table
      for (int i = 0; i < 6; i++) begin
         nb   = 8 * (int'(VEC[i][33:32]) + 1);
         mask = (64'd1 << nb) - 64'd1;
         pulse_mclr();
         mdata = VEC[i][31:0]; mbits = nb;
         host_req(VEC[i][40], VEC[i][39:34], VEC[i][33:32], VEC[i][31:0]);
         if (i == 0) begin
            while (sclk !== 1'b0) @(negedge clk);
            chk("R7 select low during transfer", 64'(cs_n), 64'd0);
            while (sclk !== 1'b1) @(negedge clk);
            per = 0;
            while (sclk !== 1'b0) begin @(negedge clk); per++; end
            while (sclk !== 1'b1) begin @(negedge clk); per++; end
            chk("R2 serial clock period", 64'(per), 64'(DIV));
         end
         wait_rsp("R4/R5", d);
         chk("R3 command byte", (cap >> nb) & 64'hFF,
             {56'd0, 1'b0, ~VEC[i][40], VEC[i][39:34]});
         if (VEC[i][40]) begin
            chk("R5 write response data", 64'(d), 64'd0);
            chk("R5 write bits MSB first", cap & mask, 64'(VEC[i][31:0]) & mask);
         end else begin
            chk("R4 read result", 64'(d), 64'(VEC[i][31:0]) & mask);
         end
         wait_clk(1);
         chk("R2 clock idles high", 64'(sclk), 64'd1);
         chk("R7 deselect after transfer", 64'(cs_n), 64'd1);
      end

      // R6 request held during a transfer
      pulse_mclr();
      mdata = 32'h0000_BEEF; mbits = 16;
      host_req(1'b0, 6'h05, 2'd1, 32'h0);
      wait_clk(3);
      chk("R6 busy during transfer", 64'(req_busy), 64'd1);
      host_req(1'b1, 6'h11, 2'd0, 32'h0000_003C);
      chk("R6 busy while held", 64'(req_busy), 64'd1);
      wait_rsp("R6 first", d);
      chk("R6 first result", 64'(d), 64'h0000_BEEF);
      wait_rsp("R6 second", d);
      chk("R6 second result", 64'(d), 64'd0);
      chk("R6 held command", (cap >> 8) & 64'hFF, 64'h11);
      chk("R6 held data", cap & 64'hFF, 64'h3C);

      // R9 automatic read
      pulse_mclr();
      mdata = 32'h5DA1_B2C3; mbits = 24;
      auto_rd_en = 1'b1;
      wait_clk(4);
      chk("R7 select low while auto enabled", 64'(cs_n), 64'd0);
      level = 1'b0;
      got = 0; rsp_seen = 0; d = '0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (rsp_valid) rsp_seen++;
         if (auto_valid) begin d = auto_data; got = 1; break; end
      end
      chk("R9 auto strobe", 64'(got), 64'd1);
      chk("R9 auto data", 64'(d), 64'h00A1_B2C3);
      chk("R9 auto command", (cap >> 24) & 64'hFF, 64'h44);
      chk("R9 no host response", 64'(rsp_seen), 64'd0);
      level = 1'b1;
      pulse_mclr();
      wait_clk(6);
      chk("R10 consumed ready is no overrun", 64'(ovr_flag), 64'd0);
      auto_rd_en = 1'b0;

      // R8 / R10 / R11 on the three-wire build
      @(negedge clk); level3 = 1'b0;
      @(negedge clk); level3 = 1'b1;
      wait_clk(4);
      chk("R8 one-clock low ignored", 64'(rdy3), 64'd0);
      level3 = 1'b0; wait_clk(4);
      chk("R8 two-clock low qualifies", 64'(rdy3), 64'd1);
      chk("R11 ready while pending no overrun", 64'(ovr3), 64'd0);
      level3 = 1'b1; wait_clk(4);
      chk("R10 missed ready sets overrun", 64'(ovr3), 64'd1);
      chk("R10 ready withdrawn", 64'(rdy3), 64'd0);
      level3 = 1'b0; wait_clk(4);
      level3 = 1'b1; wait_clk(4);
      chk("R10 overrun sticky", 64'(ovr3), 64'd1);
      chk("R11 select held low", 64'(cs3_bad), 64'd0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule